// File: doc/BRIEF.md
# UART Sleep and Wake-Up Controller

This block manages low-power operation for a two-channel UART. It watches each channel's interrupt state, sleep-enable bit, modem-status delta bits and receive-line level, and lets the device stop its main oscillator only when every channel is quiet. While asleep it watches the wake sources. These are a falling edge on a receive line, a level change on a modem input, and a transmit load strobe. When one fires it restarts the oscillator, waits a programmable startup count, and raises a per-channel wake interrupt.

The block returns to sleep by itself once the host has cleared every interrupt. If the wake came from a modem input, the host must also read that channel's modem-status register first. A strap input selects bus isolation. When the strap is high and the device is asleep, the bus-isolate output goes high so the host bus inputs can be gated off. In that mode a transmit load cannot wake the device.

The controller has four states. RUN means the clock is running and the idle conditions are checked each cycle. SLEEP means the oscillator is stopped. WARMUP counts the oscillator startup cycles. GUARD is one cycle in which sleep entry is blocked. The transitions are:
- RUN to SLEEP when the idle test holds.
- SLEEP to WARMUP on a wake event or when sleep is disabled.
- WARMUP to GUARD after the startup count.
- GUARD to RUN unconditionally.

Top module: `uart_sleep_ctrl`

## Requirements
- R1: Leaving RUN for SLEEP requires, in the same cycle, all of the following: no `irq_pend` bit set, every `sleep_en` bit set, every `msr_delta` bit clear, every `rx_in` bit high, no `wake_irq` bit set and no modem-wake hold outstanding. The oscillator enable then drops on the next clock edge.
- R2: `osc_en` is 0 only in SLEEP. `awake` is 1 only in RUN and GUARD.
- R3: With `iso_strap` low, each of the following in SLEEP moves the block to WARMUP on the next edge: a high-to-low change of `rx_in[c]`, a pulse on `tx_load[c]`, or a change of any bit of `modem_in[4c+3:4c]`.
- R4: A wake event on channel c sets `wake_irq[c]` (bit c of the vector) on the same edge that restarts the oscillator. A pulse on `isr_rd[c]` clears it.
- R5: After a wake caused by a modem input on channel c, the block stays out of SLEEP until `msr_rd[c]` is pulsed, even once `wake_irq` is cleared.
- R6: Sleep is never entered while any `irq_pend` bit is set. Clearing any `sleep_en` bit while asleep restarts the oscillator without setting `wake_irq`.
- R7: `bus_iso` equals 1 exactly when the block is in SLEEP, `iso_strap` is 1 and every `sleep_en` bit is 1. Dropping `iso_strap` while asleep clears `bus_iso` and leaves the oscillator stopped.
- R8: With `iso_strap` high, a `tx_load` pulse in SLEEP leaves `osc_en` at 0 and `wake_irq` at 0.
- R9: After a wake edge, `awake` stays 0 for exactly `STARTUP_CYC` cycles and then returns to 1.
- R10: After reset, `osc_en` is 1, `awake` is 1, `bus_iso` is 0 and `wake_irq` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock for the controller |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_pend | input | NCH | Per-channel interrupt-pending flag |
| sleep_en | input | NCH | Per-channel sleep-enable bit |
| msr_delta | input | 4*NCH | Modem-status delta bits, four per channel |
| rx_in | input | NCH | Receive line levels |
| modem_in | input | 4*NCH | Modem input pin levels, four per channel |
| tx_load | input | NCH | Transmit load strobe per channel |
| msr_rd | input | NCH | Modem-status read strobe per channel |
| isr_rd | input | NCH | Interrupt-source read strobe per channel |
| iso_strap | input | 1 | Bus-isolation strap |
| osc_en | output | 1 | Main oscillator enable |
| bus_iso | output | 1 | Host bus isolation enable |
| wake_irq | output | NCH | Per-channel wake-up interrupt flag |
| awake | output | 1 | Clock is up and startup count has elapsed |

## Verification
The bench builds the block with two channels and `STARTUP_CYC` = 4. With these values a full sweep of all 256 combinations of the eight sleep blockers is practical: two pending flags, two cleared enables, a delta per channel and a low receive line per channel. The same values make it practical to sweep every single wake source (both receive lines, both transmit strobes and all eight modem pins) with the strap at both values. The short startup count lets every wake be followed through the full WARMUP count, the interrupt clear, the modem-status hold and the return to SLEEP.

// File: rtl/uart_sleep_pkg.sv
package uart_sleep_pkg;
    typedef enum logic [1:0] {
        ST_RUN    = 2'd0,
        ST_SLEEP  = 2'd1,
        ST_WARMUP = 2'd2,
        ST_GUARD  = 2'd3
    } slp_state_e;

    localparam int unsigned MDM_W = 4;
endpackage

// File: rtl/wake_detect.sv
module wake_detect #(
    parameter int unsigned MW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rx_in,
    input  logic [MW-1:0] modem_in,
    output logic          rx_fall,
    output logic          modem_chg
);
    logic          rx_q;
    logic [MW-1:0] mdm_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_q  <= 1'b1;
            mdm_q <= '0;
        end else begin
            rx_q  <= rx_in;
            mdm_q <= modem_in;
        end
    end

    assign rx_fall   = rx_q & ~rx_in;
    assign modem_chg = |(mdm_q ^ modem_in);
endmodule

// File: rtl/wake_flags.sv
module wake_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic set_irq,
    input  logic clr_irq,
    input  logic set_hold,
    input  logic clr_hold,
    output logic irq,
    output logic hold
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq  <= 1'b0;
            hold <= 1'b0;
        end else begin
            if (set_irq)       irq <= 1'b1;
            else if (clr_irq)  irq <= 1'b0;
            if (set_hold)      hold <= 1'b1;
            else if (clr_hold) hold <= 1'b0;
        end
    end
endmodule

// File: rtl/uart_sleep_ctrl.sv
module uart_sleep_ctrl
    import uart_sleep_pkg::*;
#(
    parameter int unsigned NCH         = 2,
    parameter int unsigned STARTUP_CYC = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NCH-1:0]       irq_pend,
    input  logic [NCH-1:0]       sleep_en,
    input  logic [NCH*MDM_W-1:0] msr_delta,
    input  logic [NCH-1:0]       rx_in,
    input  logic [NCH*MDM_W-1:0] modem_in,
    input  logic [NCH-1:0]       tx_load,
    input  logic [NCH-1:0]       msr_rd,
    input  logic [NCH-1:0]       isr_rd,
    input  logic                 iso_strap,
    output logic                 osc_en,
    output logic                 bus_iso,
    output logic [NCH-1:0]       wake_irq,
    output logic                 awake
);
    localparam int unsigned CW = $clog2(STARTUP_CYC + 1);
    localparam logic [CW-1:0] CNT_LAST = CW'(STARTUP_CYC - 1);

    slp_state_e state, state_nx;
    logic [CW-1:0]  cnt;
    logic [NCH-1:0] rx_fall, mdm_chg, evt, hold;
    logic           in_sleep, idle_ok, any_evt, all_en;

    assign in_sleep = (state == ST_SLEEP);
    assign all_en   = &sleep_en;

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        wake_detect #(.MW(MDM_W)) u_det (
            .clk       (clk),
            .rst_n     (rst_n),
            .rx_in     (rx_in[c]),
            .modem_in  (modem_in[c*MDM_W +: MDM_W]),
            .rx_fall   (rx_fall[c]),
            .modem_chg (mdm_chg[c])
        );

        // A transmit load is a host bus access: blocked when isolation is strapped.
        assign evt[c] = rx_fall[c] | mdm_chg[c] | (tx_load[c] & ~iso_strap);

        wake_flags u_flg (
            .clk      (clk),
            .rst_n    (rst_n),
            .set_irq  (in_sleep & evt[c]),
            .clr_irq  (isr_rd[c]),
            .set_hold (in_sleep & mdm_chg[c]),
            .clr_hold (msr_rd[c]),
            .irq      (wake_irq[c]),
            .hold     (hold[c])
        );
    end

    assign any_evt = |evt;
    assign idle_ok = ~|irq_pend & all_en & ~|msr_delta & (&rx_in)
                   & ~|wake_irq & ~|hold;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_RUN:    if (idle_ok) state_nx = ST_SLEEP;
            ST_SLEEP:  if (any_evt || !all_en) state_nx = ST_WARMUP;
            ST_WARMUP: if (cnt == CNT_LAST) state_nx = ST_GUARD;
            ST_GUARD:  state_nx = ST_RUN;
            default:   state_nx = ST_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_RUN;
            cnt   <= '0;
        end else begin
            state <= state_nx;
            cnt   <= (state == ST_WARMUP) ? cnt + 1'b1 : '0;
        end
    end

    always_comb begin
        osc_en  = 1'b1;
        awake   = 1'b0;
        bus_iso = 1'b0;
        unique case (state)
            ST_RUN:    awake = 1'b1;
            ST_SLEEP: begin
                osc_en  = 1'b0;
                bus_iso = iso_strap & all_en;
            end
            ST_WARMUP: awake = 1'b0;
            ST_GUARD:  awake = 1'b1;
            default:   awake = 1'b1;
        endcase
    end
endmodule

// File: rtl/uart_sleep_ctrl_chk.sv
module uart_sleep_ctrl_chk #(
    parameter int unsigned NCH = 2,
    parameter int unsigned MW  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic [NCH-1:0]    irq_pend,
    input logic [NCH-1:0]    sleep_en,
    input logic [NCH*MW-1:0] msr_delta,
    input logic [NCH-1:0]    rx_in,
    input logic              iso_strap,
    input logic              osc_en,
    input logic              bus_iso,
    input logic [NCH-1:0]    wake_irq,
    input logic              awake,
    input logic [NCH-1:0]    rx_fall,
    input logic [NCH-1:0]    mdm_chg
);
    a_r1_entry_conditions: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(osc_en) |-> $past(~|irq_pend && (&sleep_en) && ~|msr_delta && (&rx_in)));

    a_r6_no_sleep_pending: assert property (@(posedge clk) disable iff (!rst_n)
        (osc_en && |irq_pend) |=> osc_en);

    a_r7_iso_only_asleep: assert property (@(posedge clk) disable iff (!rst_n)
        bus_iso |-> (!osc_en && iso_strap));

    a_r4_irq_with_restart: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(|wake_irq) |-> $rose(osc_en));

    a_r9_not_awake_at_restart: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(osc_en) |-> !awake);

    a_r8_tx_blocked_iso: assert property (@(posedge clk) disable iff (!rst_n)
        (!osc_en && iso_strap && (&sleep_en) && ~|rx_fall && ~|mdm_chg) |=> !osc_en);
endmodule

bind uart_sleep_ctrl uart_sleep_ctrl_chk #(.NCH(NCH), .MW(uart_sleep_pkg::MDM_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq_pend  (irq_pend),
    .sleep_en  (sleep_en),
    .msr_delta (msr_delta),
    .rx_in     (rx_in),
    .iso_strap (iso_strap),
    .osc_en    (osc_en),
    .bus_iso   (bus_iso),
    .wake_irq  (wake_irq),
    .awake     (awake),
    .rx_fall   (rx_fall),
    .mdm_chg   (mdm_chg)
);

// File: tb/uart_sleep_ctrl_tb.sv
`timescale 1ns/1ps
module uart_sleep_ctrl_tb;
    localparam int NCH = 2;
    localparam int SC  = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] irq_pend = '0, sleep_en = '0, rx_in = 2'b11;
    logic [1:0] tx_load = '0, msr_rd = '0, isr_rd = '0;
    logic [7:0] msr_delta = '0, modem_in = '0;
    logic       iso_strap = 1'b0;
    logic       osc_en, bus_iso, awake;
    logic [1:0] wake_irq;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    uart_sleep_ctrl #(.NCH(NCH), .STARTUP_CYC(SC)) u_dut (
        .clk(clk), .rst_n(rst_n), .irq_pend(irq_pend), .sleep_en(sleep_en),
        .msr_delta(msr_delta), .rx_in(rx_in), .modem_in(modem_in),
        .tx_load(tx_load), .msr_rd(msr_rd), .isr_rd(isr_rd),
        .iso_strap(iso_strap), .osc_en(osc_en), .bus_iso(bus_iso),
        .wake_irq(wake_irq), .awake(awake)
    );

    task automatic tick(input int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        tick(2);
        rst_n = 1'b1;
        tick(1);
        // R10 reset state
        chk("R10 osc_en", int'(osc_en), 1);
        chk("R10 awake", int'(awake), 1);
        chk("R10 bus_iso", int'(bus_iso), 0);
        chk("R10 wake_irq", int'(wake_irq), 0);

        // R1 / R6: sweep all blocker combinations
        for (int m = 0; m < 256; m++) begin
            irq_pend  = m[1:0];
            sleep_en  = ~m[3:2];
            msr_delta = {3'b0, m[5], 3'b0, m[4]};
            rx_in     = ~m[7:6];
            tick(2);
            chk((m[1:0] != 0) ? "R6 pending blocks sleep" : "R1 sleep entry",
                int'(osc_en), (m == 0) ? 0 : 1);
            sleep_en = 2'b00;
            tick(SC + 3);
            chk("R6 disable exits", int'(osc_en), 1);
            chk("R6 disable no wake irq", int'(wake_irq), 0);
            irq_pend = '0; msr_delta = '0; rx_in = 2'b11;
        end

        // R3/R4/R5/R7/R8/R9: sweep wake sources with both strap values
        for (int s = 0; s < 2; s++) begin
            for (int src = 0; src < 12; src++) begin
                int ch;
                bit is_tx, is_mdm;
                int n;
                is_tx  = (src == 2 || src == 3);
                is_mdm = (src >= 4);
                ch = (src < 2) ? src : (is_tx ? src - 2 : (src - 4) / 4);
                iso_strap = s[0];
                sleep_en  = 2'b11;
                tick(2);
                chk("R1 enter sleep", int'(osc_en), 0);
                chk("R7 bus_iso asleep", int'(bus_iso), s);
                if (src < 2)      rx_in[ch] = 1'b0;
                else if (is_tx)   tx_load[ch] = 1'b1;
                else              modem_in[src - 4] = ~modem_in[src - 4];
                tick(1);
                rx_in = 2'b11;
                tx_load = '0;
                if (is_tx && s == 1) begin
                    chk("R8 tx no wake iso", int'(osc_en), 0);
                    chk("R8 tx no irq iso", int'(wake_irq), 0);
                    iso_strap = 1'b0;
                    tick(1);
                    chk("R7 strap low ends iso", int'(bus_iso), 0);
                    chk("R7 strap low stays asleep", int'(osc_en), 0);
                    tx_load[ch] = 1'b1;
                    tick(1);
                    tx_load = '0;
                end
                chk("R3 wake", int'(osc_en), 1);
                chk("R4 wake_irq set", int'(wake_irq), 1 << ch);
                chk("R2 bus_iso off awake", int'(bus_iso), 0);
                n = 0;
                while (!awake && n < 50) begin
                    n++;
                    tick(1);
                end
                chk("R9 startup count", n, SC);
                isr_rd[ch] = 1'b1;
                tick(1);
                isr_rd = '0;
                chk("R4 isr read clears", int'(wake_irq), 0);
                if (is_mdm) begin
                    tick(3);
                    chk("R5 hold until msr read", int'(osc_en), 1);
                    msr_rd[ch] = 1'b1;
                    tick(1);
                    msr_rd = '0;
                end
                tick(2);
                chk(is_mdm ? "R5 resleep after msr read" : "R2 resleep",
                    int'(osc_en), 0);
                sleep_en = 2'b00;
                tick(SC + 3);
            end
        end

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule